// File: doc/BRIEF.md
# Write-Guarded Memory Chip-Enable Gate

This block sits between a processor's active-low memory chip-enable and the memory it selects. The goal is that no write can reach the memory while the supply is unreliable. While the supply flag reports a good rail and no system reset is being held, the enable passes straight through with no register in the path. When the supply drops, which also covers running from the backup battery, the output is driven inactive at once.

A reset can arrive while an access is already under way. In that case the block does not cut the access off. The output stays asserted until the processor releases the enable or until a fixed grace window runs out, whichever happens first. After that, the output stays inactive until reset goes away. If the enable is already released when reset arrives, there is no grace window. Once reset or the supply fault clears, the output stays inactive for one more clock and then follows the input again.

The grace window is the parameter `GRACE_CYC`, counted in clock cycles. Its default of 750 cycles is 15 us at 50 MHz.

Top module: `ce_write_guard`

## Requirements
- R1: While `vdd_good` is 1 and `rst_asserted` is 0, and both held in the previous cycle as well, `mem_ce_out_n` equals `mem_ce_in_n` in the same cycle.
- R2: In any cycle where `vdd_good` is 0, `mem_ce_out_n` is 1, whatever `rst_asserted` and `mem_ce_in_n` are.
- R3: If `mem_ce_in_n` is 0 in the first cycle that `rst_asserted` is 1 and stays 0, `mem_ce_out_n` is 0 for exactly `GRACE_CYC` cycles, counting that first cycle, and is 1 from the next cycle on.
- R4: If `mem_ce_in_n` rises during the grace window, `mem_ce_out_n` is 1 in that same cycle. It then stays 1 for as long as `rst_asserted` is 1, even if the input falls again.
- R5: If `mem_ce_in_n` is 1 in the first cycle that `rst_asserted` is 1, `mem_ce_out_n` is 1 from that cycle on while reset is held.
- R6: After a lockout, the first cycle with `rst_asserted` at 0 still gives `mem_ce_out_n` = 1. From the following cycle on, the output follows the input.
- R7: A supply loss ends any grace window. When the supply returns, the output is 1 in the first good cycle and stays 1 until reset is released, after which R6 applies.
- R8: If `rst_asserted` falls while the grace window is still open, the output keeps following the input with no lockout cycle.
- R9: With `GRACE_CYC` = 1, only the first reset cycle may pass a low enable. The output is 1 from the second reset cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| vdd_good | input | 1 | 1 while the supply is above the valid threshold |
| rst_asserted | input | 1 | 1 while the system reset is being held |
| mem_ce_in_n | input | 1 | Active-low chip-enable from the processor |
| mem_ce_out_n | output | 1 | Guarded active-low chip-enable to the memory |

## Verification
The bench steps the cycle in which the enable is released across every point of the grace window and past its end. It runs this on a five-cycle instance and on a one-cycle instance side by side. An off-by-one counter would cut the window a cycle short or hold it a cycle long. A lockout that is not sticky would let a second low pulse through. The bench also checks a release of reset inside the window, which a design that always locks would wrongly block for a cycle. It covers a supply loss in mid-window and the single lockout cycle at recovery, so that a design that resumes early or gets stuck would show up at the ports.

// File: rtl/ce_guard_pkg.sv
package ce_guard_pkg;
   typedef enum logic [1:0] {
      GATE_PASS  = 2'd0,
      GATE_GRACE = 2'd1,
      GATE_LOCK  = 2'd2
   } gate_mode_e;
endpackage

// File: rtl/ce_guard_timer.sv
module ce_guard_timer #(
   parameter int GRACE_CYC = 750
) (
   input  logic clk,
   input  logic en,
   input  logic load,
   input  logic step,
   output logic last
);
   localparam int CW = (GRACE_CYC > 1) ? $clog2(GRACE_CYC + 1) : 1;

   generate
      if (GRACE_CYC > 1) begin : g_cnt
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (load)      cnt <= CW'(1);
            else if (step) cnt <= cnt + CW'(1);
         end
         assign last = (cnt == CW'(GRACE_CYC - 1));

         AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!en)
            step |-> (cnt >= CW'(1) && cnt < CW'(GRACE_CYC - 1))); // R3
      end else begin : g_none
         logic unused_tie;
         assign unused_tie = ^{clk, en, load, step};
         assign last = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/ce_guard_ctrl.sv
module ce_guard_ctrl
   import ce_guard_pkg::*;
#(
   parameter int GRACE_CYC = 750
) (
   input  logic       clk,
   input  logic       vdd_good,
   input  logic       rst_asserted,
   input  logic       mem_ce_in_n,
   input  logic       tmr_last,
   output gate_mode_e mode,
   output logic       tmr_load,
   output logic       tmr_step
);
   localparam bit ONE_SHOT = (GRACE_CYC == 1);

   gate_mode_e mode_nx;

   always_comb begin
      mode_nx  = GATE_LOCK;
      tmr_load = 1'b0;
      tmr_step = 1'b0;
      if (vdd_good) begin
         unique case (mode)
            GATE_PASS: begin
               if (!rst_asserted)                mode_nx = GATE_PASS;
               else if (mem_ce_in_n || ONE_SHOT) mode_nx = GATE_LOCK;
               else begin
                  mode_nx  = GATE_GRACE;
                  tmr_load = 1'b1;
               end
            end
            GATE_GRACE: begin
               if (!rst_asserted)                mode_nx = GATE_PASS;
               else if (mem_ce_in_n || tmr_last) mode_nx = GATE_LOCK;
               else begin
                  mode_nx  = GATE_GRACE;
                  tmr_step = 1'b1;
               end
            end
            default: mode_nx = rst_asserted ? GATE_LOCK : GATE_PASS;
         endcase
      end
   end

   always_ff @(posedge clk) mode <= mode_nx;

   AST_GRACE_AFTER_RST: assert property (@(posedge clk) disable iff (!vdd_good)
      (mode == GATE_GRACE) |-> $past(rst_asserted)); // R3
   AST_HIGH_AT_ASSERT: assert property (@(posedge clk) disable iff (!vdd_good)
      ($rose(rst_asserted) && mem_ce_in_n && mode == GATE_PASS) |=> (mode == GATE_LOCK)); // R5
   AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!vdd_good)
      (mode == GATE_LOCK && !rst_asserted) |=> (mode == GATE_PASS)); // R6
endmodule

// File: rtl/ce_write_guard.sv
module ce_write_guard
   import ce_guard_pkg::*;
#(
   parameter int GRACE_CYC = 750
) (
   input  logic clk,
   input  logic vdd_good,
   input  logic rst_asserted,
   input  logic mem_ce_in_n,
   output logic mem_ce_out_n
);
   generate
      if (GRACE_CYC < 1) begin : g_bad_grace
         $error("ce_write_guard: GRACE_CYC must be at least 1");
      end
   endgenerate

   gate_mode_e mode;
   logic       tmr_load, tmr_step, tmr_last;

   ce_guard_ctrl #(.GRACE_CYC(GRACE_CYC)) u_ctrl (
      .clk          (clk),
      .vdd_good     (vdd_good),
      .rst_asserted (rst_asserted),
      .mem_ce_in_n  (mem_ce_in_n),
      .tmr_last     (tmr_last),
      .mode         (mode),
      .tmr_load     (tmr_load),
      .tmr_step     (tmr_step)
   );

   ce_guard_timer #(.GRACE_CYC(GRACE_CYC)) u_timer (
      .clk  (clk),
      .en   (vdd_good),
      .load (tmr_load),
      .step (tmr_step),
      .last (tmr_last)
   );

   assign mem_ce_out_n = (vdd_good && mode != GATE_LOCK) ? mem_ce_in_n : 1'b1;

   AST_FOLLOW: assert property (@(posedge clk) disable iff (!vdd_good)
      (!rst_asserted && $past(vdd_good) && !$past(rst_asserted))
      |-> (mem_ce_out_n == mem_ce_in_n)); // R1
   AST_NO_REOPEN: assert property (@(posedge clk) disable iff (!vdd_good)
      (rst_asserted && $past(rst_asserted) && $past(mem_ce_out_n)) |-> mem_ce_out_n); // R4
endmodule

// File: tb/ce_write_guard_bench.sv
module ce_write_guard_bench;
   localparam int GA = 5;

   logic clk = 1'b0;
   logic vdd = 1'b0, rst = 1'b0, ce = 1'b0;
   logic out_a, out_b;
   int   n_tests = 0, n_fail = 0;

   always #10 clk = ~clk;

   ce_write_guard #(.GRACE_CYC(GA)) u_ce_write_guard (
      .clk(clk), .vdd_good(vdd), .rst_asserted(rst), .mem_ce_in_n(ce), .mem_ce_out_n(out_a));
   ce_write_guard #(.GRACE_CYC(1)) u_ce_write_guard_one (
      .clk(clk), .vdd_good(vdd), .rst_asserted(rst), .mem_ce_in_n(ce), .mem_ce_out_n(out_b));

   task automatic chk(string req, logic act, logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(logic v, logic r, logic c);
      @(negedge clk);
      vdd = v; rst = r; ce = c;
      #5;
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R2: supply low at start and for every input combination
      for (int i = 0; i < 3; i++) begin
         drive(1'b0, 1'b0, 1'b0);
         chk("R2", out_a, 1'b1); chk("R2", out_b, 1'b1);
      end
      for (int m = 0; m < 4; m++) begin
         drive(1'b0, m[1], m[0]);
         chk("R2", out_a, 1'b1); chk("R2", out_b, 1'b1);
      end
      // R7: supply returns with reset idle: one lockout cycle, then follow
      drive(1'b1, 1'b0, 1'b0); chk("R7", out_a, 1'b1); chk("R7", out_b, 1'b1);
      drive(1'b1, 1'b0, 1'b0); chk("R7", out_a, 1'b0); chk("R7", out_b, 1'b0);
      // R1: pass-through
      for (int m = 0; m < 4; m++) begin
         drive(1'b1, 1'b0, m[0]);
         chk("R1", out_a, m[0]); chk("R1", out_b, m[0]);
      end
      // R3/R4/R5/R9: release point j swept across and beyond the window
      for (int j = 1; j <= 8; j++) begin
         drive(1'b1, 1'b0, 1'b0); chk("R1", out_a, 1'b0);
         for (int k = 1; k <= 8; k++) begin
            drive(1'b1, 1'b1, (k == j));
            if (j == 1)     chk("R5", out_a, 1'b1);
            else if (k > j) chk("R4", out_a, 1'b1);
            else            chk("R3", out_a, (k < j && k <= GA) ? 1'b0 : 1'b1);
            chk("R9", out_b, (k < j && k <= 1) ? 1'b0 : 1'b1);
         end
         drive(1'b1, 1'b0, 1'b0); chk("R6", out_a, 1'b1); chk("R6", out_b, 1'b1);
         drive(1'b1, 1'b0, 1'b0); chk("R6", out_a, 1'b0); chk("R6", out_b, 1'b0);
      end
      // R8: reset released inside the window
      for (int d = 2; d <= GA; d++) begin
         drive(1'b1, 1'b1, 1'b0); chk("R3", out_a, 1'b0);
         for (int k = 2; k < d; k++) begin
            drive(1'b1, 1'b1, 1'b0); chk("R3", out_a, 1'b0);
         end
         drive(1'b1, 1'b0, 1'b0); chk("R8", out_a, 1'b0); chk("R6", out_b, 1'b1);
         drive(1'b1, 1'b0, 1'b1); chk("R8", out_a, 1'b1); chk("R1", out_b, 1'b1);
         drive(1'b1, 1'b0, 1'b0); chk("R8", out_a, 1'b0); chk("R1", out_b, 1'b0);
      end
      // R7: supply loss in mid-window
      drive(1'b1, 1'b1, 1'b0); chk("R3", out_a, 1'b0);
      drive(1'b1, 1'b1, 1'b0); chk("R3", out_a, 1'b0);
      drive(1'b0, 1'b1, 1'b0); chk("R2", out_a, 1'b1);
      drive(1'b1, 1'b1, 1'b0); chk("R7", out_a, 1'b1); chk("R7", out_b, 1'b1);
      drive(1'b1, 1'b1, 1'b0); chk("R7", out_a, 1'b1);
      drive(1'b1, 1'b0, 1'b0); chk("R6", out_a, 1'b1);
      drive(1'b1, 1'b0, 1'b0); chk("R6", out_a, 1'b0); chk("R6", out_b, 1'b0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule